// File: doc/BRIEF.md
# Event-Driven Programmable Timer

This block is a 32-bit counter timer in which outputs are not tied to fixed compare channels. A prescaler advances the counter once every (prescale+1) clocks. The counter either counts up and restarts at zero, or counts up to a limit and then back down to zero. A bank of match/capture registers feeds a set of events. An event fires when the counter equals the value in its chosen match register, and only while the current state number is enabled in that event's state mask.

Fired events act in several ways. They set or clear output pins through per-output event masks. A two-bit resolution field settles a simultaneous set and clear, and a direction field can swap set and clear while the counter runs in one direction, so a single pulse match yields a center-aligned PWM. Events chosen in the limit mask restart or reverse the counter. Each match register reloads from its shadow at every limit event and while the counter is halted, so a duty-cycle change takes effect at a period boundary. A register in capture mode latches the counter instead. Fired events raise sticky flags, which software clears by writing 1s, and an interrupt is raised for every flag that is also enabled.

Configuration uses a plain single-cycle write strobe. A combinational read port returns the counter, the flags and the match/capture registers. Neither port has back-pressure: a write is taken on every clock edge where `wr_en` is high, and `rd_data` follows `rd_addr` within the same cycle.

Top module: `evt_timer`

## Requirements
- R1: Control word at address 0x00 holds halt in bit 0, clear-counter in bit 1, bidirectional mode in bit 2 and the prescale value PRE in bits 15:8. While running, the counter changes only once every PRE+1 clocks. After a clearing write that releases halt, the counter holds k after 4k further clocks when PRE=3.
- R2: In up mode, a firing event whose bit is set in the limit mask (address 0x05) makes the next counter value zero.
- R3: In bidirectional mode, a limit event reverses the counter to count down. At zero it counts up again, so one period lasts 2·P counter steps for a limit match of P.
- R4: Event e is configured at address 0x18+e, with match select in bits 2:0 and state-enable mask in bits 11:8. It fires on a counter step where the selected match register (written at 0x08+i) equals the counter, and only while the bit for the current state (address 0x01) is set in its mask.
- R5: Output o is configured at address 0x20+o, with set-event mask in bits 7:0, clear-event mask in bits 15:8, resolution in bits 17:16 and direction control in bits 19:18. A set alone drives 1 and a clear alone drives 0. When both happen at once, resolution 00 keeps the output, 01 sets it, 10 clears it and 11 toggles it. A write to address 0x02 loads all outputs directly.
- R6: Direction control 01 swaps set and clear while the counter counts down, and 10 swaps them while it counts up.
- R7: An edge-aligned PWM with period match P and pulse match D is high for D+1 of every P+1 steps. A center-aligned PWM (bidirectional mode, clear on pulse, swap 01) is high for 2·D of every 2·P steps. A pulse match above P (P+2) gives 100% duty.
- R8: A register whose bit is set in the capture-mode mask (address 0x06) latches the counter when an event in its capture mask (address 0x28+i) fires, and otherwise holds its value.
- R9: Firing sets flag bits, which are read at address 0x03. Writing 1s to address 0x03 clears them. `irq` is high exactly when a flag is set and its bit is set in the interrupt enable at address 0x04.
- R10: While halt is set, the counter holds its value. A clear-counter write zeroes it.
- R11: A write to 0x10+i loads only the reload shadow. The match register takes the new value at the next limit event, or one clock later while halted. A write to 0x08+i loads both the match register and its shadow.
- R12: After reset the counter is 0, the block is halted, all outputs and flags are 0 and `irq` is low. Read address 0x07 returns the counter and 0x08+i returns register i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 6 | Read address |
| rd_data | output | 32 | Read data (combinational) |
| out_pins | output | 4 | Event-driven outputs |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 8 events, 8 match/capture registers, 4 states, 4 outputs, a 32-bit counter and an 8-bit prescale. With these values, several events can target one output at once, so every resolution code can be exercised, and one register can be set to capture while others match. Periods are kept small and prescale values low, so each PWM vector settles and is measured over whole periods in a few hundred clocks. The 32-bit width means the counter never wraps within a test, so an event missed under state gating stays missed until a clearing write.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;
  localparam int ADDR_W = 6;
  localparam logic [ADDR_W-1:0] A_CTRL   = 6'h00;
  localparam logic [ADDR_W-1:0] A_STATE  = 6'h01;
  localparam logic [ADDR_W-1:0] A_OUTW   = 6'h02;
  localparam logic [ADDR_W-1:0] A_FLAG   = 6'h03;
  localparam logic [ADDR_W-1:0] A_IEN    = 6'h04;
  localparam logic [ADDR_W-1:0] A_LIMIT  = 6'h05;
  localparam logic [ADDR_W-1:0] A_MODE   = 6'h06;
  localparam logic [ADDR_W-1:0] A_CNT    = 6'h07;
  localparam logic [ADDR_W-1:0] A_MATCH  = 6'h08;
  localparam logic [ADDR_W-1:0] A_RELOAD = 6'h10;
  localparam logic [ADDR_W-1:0] A_EVENT  = 6'h18;
  localparam logic [ADDR_W-1:0] A_OUTCFG = 6'h20;
  localparam logic [ADDR_W-1:0] A_CAPEN  = 6'h28;
  localparam int F_PRE   = 8;
  localparam int F_SMASK = 8;
  localparam int F_CLRM  = 8;
  localparam int F_RES   = 16;
  localparam int F_DIRC  = 18;
  typedef enum logic [1:0] {RES_KEEP = 2'b00, RES_SET = 2'b01, RES_CLR = 2'b10, RES_TOG = 2'b11} res_e;
  typedef enum logic [1:0] {DIR_NONE = 2'b00, DIR_SWAP_DN = 2'b01, DIR_SWAP_UP = 2'b10, DIR_RSVD = 2'b11} dirc_e;
endpackage

// File: rtl/evt_timer_count.sv
module evt_timer_count #(
  parameter int CNT_W = 32,
  parameter int PRE_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             halt,
  input  logic             clr,
  input  logic             bidir,
  input  logic [PRE_W-1:0] pre,
  input  logic             lim,
  output logic [CNT_W-1:0] cnt,
  output logic             down,
  output logic             tick
);
  logic [PRE_W-1:0] pre_cnt;

  assign tick = !halt && !clr && (pre_cnt == pre);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0; pre_cnt <= '0; down <= 1'b0;
    end else if (clr) begin
      cnt <= '0; pre_cnt <= '0; down <= 1'b0;
    end else if (!halt) begin
      if (pre_cnt != pre) begin
        pre_cnt <= pre_cnt + 1'b1;
      end else begin
        pre_cnt <= '0;
        if (!bidir) begin
          down <= 1'b0;
          cnt  <= lim ? '0 : cnt + 1'b1;
        end else if (!down) begin
          if (lim) begin
            down <= 1'b1;
            cnt  <= cnt - 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end else if (cnt == '0) begin
          down <= 1'b0;
          cnt  <= {{(CNT_W-1){1'b0}}, 1'b1};
        end else begin
          cnt <= cnt - 1'b1;
        end
      end
    end
  end

  AST_HALT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    halt && !clr |=> $stable(cnt)); // R10
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !halt && !clr && !tick |=> $stable(cnt)); // R1
  AST_UP_LIMIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    tick && lim && !bidir |=> cnt == '0); // R2
endmodule

// File: rtl/evt_timer_events.sv
module evt_timer_events #(
  parameter int N_EV  = 8,
  parameter int N_MR  = 8,
  parameter int N_ST  = 4,
  parameter int CNT_W = 32,
  localparam int SEL_W = $clog2(N_MR),
  localparam int ST_W  = $clog2(N_ST)
) (
  input  logic                             tick,
  input  logic [CNT_W-1:0]                 cnt,
  input  logic [N_MR-1:0][CNT_W-1:0]       match,
  input  logic [N_MR-1:0]                  cap_mode,
  input  logic [N_EV-1:0][SEL_W-1:0]       ev_sel,
  input  logic [N_EV-1:0][N_ST-1:0]        ev_smask,
  input  logic [ST_W-1:0]                  state,
  output logic [N_EV-1:0]                  hit
);
  for (genvar e = 0; e < N_EV; e++) begin : g_ev
    assign hit[e] = tick && !cap_mode[ev_sel[e]] &&
                    (match[ev_sel[e]] == cnt) && ev_smask[e][state];
  end
endmodule

// File: rtl/evt_timer_out.sv
module evt_timer_out
  import evt_timer_pkg::*;
#(
  parameter int N_EV = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N_EV-1:0] hit,
  input  logic [N_EV-1:0] set_m,
  input  logic [N_EV-1:0] clr_m,
  input  res_e            res,
  input  dirc_e           dirc,
  input  logic            down,
  input  logic            sw_we,
  input  logic            sw_val,
  output logic            q
);
  logic s_raw, c_raw, swap, s_eff, c_eff;

  assign s_raw = |(hit & set_m);
  assign c_raw = |(hit & clr_m);
  assign swap  = (dirc == DIR_SWAP_DN && down) || (dirc == DIR_SWAP_UP && !down);
  assign s_eff = swap ? c_raw : s_raw;
  assign c_eff = swap ? s_raw : c_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= 1'b0;
    else if (sw_we) q <= sw_val;
    else if (s_eff && c_eff) begin
      case (res)
        RES_SET: q <= 1'b1;
        RES_CLR: q <= 1'b0;
        RES_TOG: q <= !q;
        default: q <= q;
      endcase
    end
    else if (s_eff) q <= 1'b1;
    else if (c_eff) q <= 1'b0;
  end

  AST_OUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !s_raw && !c_raw && !sw_we |=> $stable(q)); // R5
endmodule

// File: rtl/evt_timer.sv
module evt_timer
  import evt_timer_pkg::*;
#(
  parameter int N_EV  = 8,
  parameter int N_MR  = 8,
  parameter int N_ST  = 4,
  parameter int N_OUT = 4,
  parameter int CNT_W = 32,
  parameter int PRE_W = 8,
  localparam int SEL_W = $clog2(N_MR),
  localparam int ST_W  = $clog2(N_ST)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [31:0]       rd_data,
  output logic [N_OUT-1:0]  out_pins,
  output logic              irq
);
  logic                       halt, bidir, clr, down, tick, lim;
  logic [PRE_W-1:0]           pre;
  logic [ST_W-1:0]            state;
  logic [N_EV-1:0]            ien, limm, flags, hit;
  logic [N_MR-1:0]            cap_mode, cap_hit;
  logic [CNT_W-1:0]           cnt;
  logic [N_MR-1:0][CNT_W-1:0] match, reload;
  logic [N_MR-1:0][N_EV-1:0]  capen;
  logic [N_EV-1:0][SEL_W-1:0] ev_sel;
  logic [N_EV-1:0][N_ST-1:0]  ev_smask;
  logic [N_OUT-1:0][N_EV-1:0] set_m, clr_m;
  res_e                       res  [N_OUT];
  dirc_e                      dirc [N_OUT];
  logic                       flag_wr, outw;

  assign clr     = wr_en && wr_addr == A_CTRL && wr_data[1];
  assign flag_wr = wr_en && wr_addr == A_FLAG;
  assign outw    = wr_en && wr_addr == A_OUTW;
  assign lim     = |(hit & limm);
  assign irq     = |(flags & ien);

  evt_timer_count #(.CNT_W(CNT_W), .PRE_W(PRE_W)) u_count (
    .clk(clk), .rst_n(rst_n), .halt(halt), .clr(clr), .bidir(bidir), .pre(pre),
    .lim(lim), .cnt(cnt), .down(down), .tick(tick));

  evt_timer_events #(.N_EV(N_EV), .N_MR(N_MR), .N_ST(N_ST), .CNT_W(CNT_W)) u_events (
    .tick(tick), .cnt(cnt), .match(match), .cap_mode(cap_mode), .ev_sel(ev_sel),
    .ev_smask(ev_smask), .state(state), .hit(hit));

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    evt_timer_out #(.N_EV(N_EV)) u_out (
      .clk(clk), .rst_n(rst_n), .hit(hit), .set_m(set_m[o]), .clr_m(clr_m[o]),
      .res(res[o]), .dirc(dirc[o]), .down(down), .sw_we(outw), .sw_val(wr_data[o]),
      .q(out_pins[o]));
  end

  for (genvar i = 0; i < N_MR; i++) begin : g_cap
    assign cap_hit[i] = |(hit & capen[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt <= 1'b1; bidir <= 1'b0; pre <= '0; state <= '0;
      ien <= '0; limm <= '0; cap_mode <= '0;
    end else if (wr_en) begin
      case (wr_addr)
        A_CTRL:  begin halt <= wr_data[0]; bidir <= wr_data[2]; pre <= wr_data[F_PRE +: PRE_W]; end
        A_STATE: state    <= wr_data[ST_W-1:0];
        A_IEN:   ien      <= wr_data[N_EV-1:0];
        A_LIMIT: limm     <= wr_data[N_EV-1:0];
        A_MODE:  cap_mode <= wr_data[N_MR-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags <= '0;
    else flags <= (flags & ~(flag_wr ? wr_data[N_EV-1:0] : '0)) | hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match <= '0; reload <= '0; capen <= '0;
    end else begin
      for (int i = 0; i < N_MR; i++) begin
        if (wr_en && wr_addr == A_MATCH + ADDR_W'(i)) begin
          match[i]  <= wr_data[CNT_W-1:0];
          reload[i] <= wr_data[CNT_W-1:0];
        end else begin
          if (wr_en && wr_addr == A_RELOAD + ADDR_W'(i)) reload[i] <= wr_data[CNT_W-1:0];
          if (cap_mode[i]) begin
            if (cap_hit[i]) match[i] <= cnt;
          end else if (lim || halt) begin
            match[i] <= reload[i];
          end
        end
        if (wr_en && wr_addr == A_CAPEN + ADDR_W'(i)) capen[i] <= wr_data[N_EV-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_sel <= '0; ev_smask <= '0;
    end else begin
      for (int e = 0; e < N_EV; e++) begin
        if (wr_en && wr_addr == A_EVENT + ADDR_W'(e)) begin
          ev_sel[e]   <= wr_data[SEL_W-1:0];
          ev_smask[e] <= wr_data[F_SMASK +: N_ST];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_m <= '0; clr_m <= '0;
      for (int o = 0; o < N_OUT; o++) begin res[o] <= RES_KEEP; dirc[o] <= DIR_NONE; end
    end else begin
      for (int o = 0; o < N_OUT; o++) begin
        if (wr_en && wr_addr == A_OUTCFG + ADDR_W'(o)) begin
          set_m[o] <= wr_data[N_EV-1:0];
          clr_m[o] <= wr_data[F_CLRM +: N_EV];
          res[o]   <= res_e'(wr_data[F_RES +: 2]);
          dirc[o]  <= dirc_e'(wr_data[F_DIRC +: 2]);
        end
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_CNT) rd_data = 32'(cnt);
    else if (rd_addr == A_FLAG) rd_data = 32'(flags);
    for (int i = 0; i < N_MR; i++)
      if (rd_addr == A_MATCH + ADDR_W'(i)) rd_data = 32'(match[i]);
  end

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_wr |=> (flags & $past(flags)) == $past(flags)); // R9
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> cnt == '0); // R10
  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cap_mode[0] && !cap_hit[0] && !(wr_en && wr_addr == A_MATCH) && !(wr_en && wr_addr == A_MODE)
    |=> $stable(match[0])); // R8
endmodule

// File: tb/evt_timer_test.sv
module evt_timer_test;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [5:0] wr_addr = '0, rd_addr = '0;
  logic [31:0] wr_data = '0, rd_data;
  logic [3:0] out_pins;
  logic irq;
  int total = 0, bad = 0;

  always #5 clk = !clk;

  evt_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .out_pins(out_pins), .irq(irq));

  // bidir, pre, period P, pulse D, period in clocks, high clocks per period
  localparam int VEC [6][6] = '{
    '{0, 0, 9, 4, 10, 5},
    '{0, 2, 7, 3, 24, 12},
    '{0, 0, 5, 7, 6, 6},
    '{0, 1, 4, 0, 10, 2},
    '{1, 0, 8, 3, 16, 6},
    '{1, 1, 6, 2, 24, 8}
  };

  task automatic check(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    rd_addr = a; #1; d = rd_data;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    #1500000;
    bad++; total++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v, v2;
    int hi;
    do_reset();
    // R12 reset state
    check("R12 out", out_pins, 0);
    check("R12 irq", irq, 0);
    rd(6'h07, v); check("R12 counter", v, 0);
    rd(6'h03, v); check("R12 flags", v, 0);

    // R7 PWM table (also R2, R3, R5, R6)
    for (int k = 0; k < 6; k++) begin
      wr(6'h00, 32'h1);
      wr(6'h08, VEC[k][2]);
      wr(6'h09, VEC[k][3]);
      wr(6'h18, 32'h100);
      wr(6'h19, 32'h101);
      wr(6'h05, 32'h01);
      wr(6'h20, VEC[k][0] ? 32'h0004_0200 : 32'h0000_0201);
      wr(6'h02, 32'h0);
      wr(6'h00, (VEC[k][1] << 8) | (VEC[k][0] << 2) | 32'h2);
      repeat (3 * VEC[k][4]) @(negedge clk);
      hi = 0;
      for (int c = 0; c < 4 * VEC[k][4]; c++) begin
        @(negedge clk);
        if (out_pins[0]) hi++;
      end
      check($sformatf("R7 vec%0d high", k), hi, 4 * VEC[k][5]);
    end

    // R1 prescaler
    do_reset();
    wr(6'h00, 32'h0302);
    repeat (40) @(negedge clk);
    rd(6'h07, v); check("R1 prescale", v, 10);

    // R4 state gating, R9 flags and irq
    do_reset();
    wr(6'h08, 32'd3);
    wr(6'h18, 32'h200);
    wr(6'h00, 32'h2);
    repeat (10) @(negedge clk);
    rd(6'h03, v); check("R4 gated off", v, 0);
    wr(6'h01, 32'h1);
    wr(6'h00, 32'h2);
    repeat (10) @(negedge clk);
    rd(6'h03, v); check("R4 fires in state", v, 1);
    check("R9 irq disabled", irq, 0);
    wr(6'h04, 32'h1);
    check("R9 irq enabled", irq, 1);
    wr(6'h03, 32'h1);
    rd(6'h03, v); check("R9 clear flags", v, 0);
    check("R9 irq cleared", irq, 0);

    // R8 capture
    wr(6'h00, 32'h1);
    wr(6'h08, 32'd6);
    wr(6'h06, 32'h4);
    wr(6'h2A, 32'h1);
    rd(6'h0A, v); check("R8 before capture", v, 0);
    wr(6'h00, 32'h2);
    repeat (20) @(negedge clk);
    rd(6'h0A, v); check("R8 captured", v, 6);

    // R5 resolution codes
    do_reset();
    wr(6'h08, 32'd4);
    wr(6'h18, 32'h100);
    wr(6'h05, 32'h1);
    wr(6'h21, 32'h0003_0101);
    wr(6'h22, 32'h0000_0101);
    wr(6'h23, 32'h0002_0101);
    wr(6'h02, 32'hC);
    wr(6'h00, 32'h2);
    repeat (12) @(negedge clk);
    hi = 0;
    for (int c = 0; c < 20; c++) begin
      @(negedge clk);
      if (out_pins[1]) hi++;
    end
    check("R5 toggle", hi, 10);
    check("R5 keep", out_pins[2], 1);
    check("R5 clear wins", out_pins[3], 0);

    // R11 reload shadow, R10 halt and clear
    do_reset();
    wr(6'h08, 32'd199);
    wr(6'h09, 32'd50);
    wr(6'h18, 32'h100);
    wr(6'h05, 32'h1);
    wr(6'h00, 32'h2);
    for (int c = 0; c < 500; c++) begin
      @(negedge clk); rd(6'h07, v);
      if (v == 10) break;
    end
    wr(6'h11, 32'd80);
    rd(6'h09, v); check("R11 held until limit", v, 50);
    for (int c = 0; c < 500; c++) begin
      @(negedge clk); rd(6'h07, v);
      if (v == 5) break;
    end
    rd(6'h09, v); check("R11 loaded at limit", v, 80);
    wr(6'h00, 32'h1);
    rd(6'h07, v);
    repeat (20) @(negedge clk);
    rd(6'h07, v2); check("R10 halt freezes", v2, v);
    wr(6'h11, 32'd33);
    @(negedge clk);
    rd(6'h09, v); check("R11 loaded while halted", v, 33);
    wr(6'h00, 32'h3);
    rd(6'h07, v); check("R10 clear", v, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule